// File: doc/BRIEF.md
# Programmable Fractional Time Counter

This block keeps a 64-bit system time value for hardware timestamping. The value is clocked from a fixed reference clock. It does not add one on every tick. A 32-bit control word holds two fields: a period, and an increment that is pre-scaled so that the upper counter bits count whole nanoseconds and the lower bits hold fractions of a nanosecond. After every `period` reference clocks the counter adds the increment once. Software can trim the frequency in small steps by changing the increment slightly.

Software uses a small register port. It can write and read the control word, and it can read and write the time value as a low word and a high word. Reading the low word copies the high word into a shadow register, so a later high-word read matches that low word even if a carry happened between the two reads. A write to the low word is only staged. The full 64-bit value enters the counter in one step when the high word is written. Typical settings are a period of 1 with an increment of 40<<18 for a 25 MHz reference, a period of 3 with 125<<17 for 96 MHz, a period of 3 with 125<<14 for 24 MHz, and a period of 1 with 26<<19 for 38.4 MHz.

Top module: `frac_time_ctr`

## Requirements
- R1: After a synchronous active-low reset, `time_now`, the control word, `reg_rdata`, the high-word shadow and `wrap_pulse` are all zero.
- R2: While the period field (control bits 31:24) is zero, the time value never changes unless the high word is written.
- R3: With a nonzero period P, the time value grows by the increment field (control bits 23:0) exactly once every P reference clocks. It does not change in the clocks between.
- R4: A control-word write restarts the tick divider from zero. After the write edge, the first increment under the new word comes P clock edges later.
- R5: Register address 0 selects the control word, which reads back as it was written. Bits 31:24 are the period and bits 23:0 are the increment.
- R6: A read of address 1 returns the time value's bits 31:0 and copies bits 63:32 into a shadow. A read of address 2 returns that shadow, even if the counter has carried into its upper half since then.
- R7: A write to address 1 only stages the low word and leaves the time value unchanged. A write to address 2 loads {written word, staged low word} into the counter at that edge. The load takes priority over any increment due at the same edge.
- R8: An increment that passes 2^64 wraps the counter modulo 2^64. `wrap_pulse` is then high for exactly the one cycle after the wrapping edge.
- R9: Read data is registered. It appears in the cycle after the read strobe and holds until the next read. Address 3 reads as zero, and writes to address 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 time low, 2 time high, 3 unused |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| time_now | output | 64 | Current time value |
| wrap_pulse | output | 1 | One-cycle pulse after a modulo-2^64 wrap |

## Verification
The bench builds the block with its default parameters: a 64-bit time value, an 8-bit period field and a 24-bit increment field. With these widths the bench can load the counter a few increments below 2^64 to force a wrap. It can also load just below the 2^32 boundary, so that a carry into the high word falls between a low-word read and the following high-word read. Periods 0 to 3 are mixed at random, so restarts of the divider land at every point of its count.

// File: rtl/ftc_pkg.sv
// Package ftc_pkg: register selector shared by the time counter modules.
// Assumes a two-bit register address on the software port.
package ftc_pkg;
    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_TLO  = 2'd1,
        REG_THI  = 2'd2,
        REG_VOID = 2'd3
    } ftc_reg_e;
endpackage

// File: rtl/ftc_tick_div.sv
// ftc_tick_div: counts reference clocks and asserts tick once every
// `period` clocks. A period of zero stops it. restart clears the count.
// Assumes that every period change comes with a restart, so the count
// always stays below the period.
module ftc_tick_div #(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] period,
    input  logic             restart,
    output logic             tick,
    output logic [PER_W-1:0] cnt_o
);
    logic [PER_W-1:0] cnt_q;

    // Tick on the last clock of each period.
    always_comb tick = (period != '0) && (cnt_q == period - 1'b1);

    // Advance the count, or clear it on restart, stop or period end.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (restart)         cnt_q <= '0;
        else if (period == '0)    cnt_q <= '0;
        else if (tick)            cnt_q <= '0;
        else                      cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/ftc_time_acc.sv
// ftc_time_acc: holds the time value. It adds the increment on a tick,
// or takes a full load, which has priority. It flags a carry out of the
// top bit with a one-cycle wrap pulse.
// Assumes INC_W <= TIME_W.
module ftc_time_acc #(
    parameter int TIME_W = 64,
    parameter int INC_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [INC_W-1:0]  incr,
    input  logic              load,
    input  logic [TIME_W-1:0] load_val,
    output logic [TIME_W-1:0] time_q,
    output logic              wrap
);
    logic [TIME_W:0] sum;

    // Add with one extra bit to catch the carry out.
    always_comb sum = {1'b0, time_q} + (TIME_W+1)'(incr);

    // Update the time value and the wrap flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_q <= '0;
            wrap   <= 1'b0;
        end else if (load) begin
            time_q <= load_val;
            wrap   <= 1'b0;
        end else if (tick) begin
            time_q <= sum[TIME_W-1:0];
            wrap   <= sum[TIME_W];
        end else begin
            wrap   <= 1'b0;
        end
    end
endmodule

// File: rtl/ftc_reg_port.sv
// ftc_reg_port: the software register port. It holds the control word,
// the staged low word for loads and the high-word read shadow, and it
// returns registered read data.
// Assumes TIME_W > WORD_W and TIME_W <= 2*WORD_W.
module ftc_reg_port
    import ftc_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [TIME_W-1:0] time_q,
    output logic [WORD_W-1:0] ctrl_q,
    output logic              ctrl_wr,
    output logic              load,
    output logic [TIME_W-1:0] load_val,
    output logic [WORD_W-1:0] lo_stage,
    output logic [WORD_W-1:0] rdata
);
    localparam int HI_W = TIME_W - WORD_W;

    ftc_reg_e        sel;
    logic [HI_W-1:0] shadow_q;

    // Decode the strobes.
    always_comb begin
        sel     = ftc_reg_e'(addr);
        ctrl_wr = wr_en && (sel == REG_CTRL);
        load    = wr_en && (sel == REG_THI);
    end

    // The full load value is the written high part plus the staged low word.
    assign load_val = {wdata[HI_W-1:0], lo_stage};

    // Register the control word and the staged low word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            lo_stage <= '0;
        end else if (wr_en) begin
            if (sel == REG_CTRL) ctrl_q   <= wdata;
            if (sel == REG_TLO)  lo_stage <= wdata;
        end
    end

    // Register read data and capture the shadow on a low-word read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata    <= '0;
            shadow_q <= '0;
        end else if (rd_en) begin
            unique case (sel)
                REG_CTRL: rdata <= ctrl_q;
                REG_TLO: begin
                    rdata    <= time_q[WORD_W-1:0];
                    shadow_q <= time_q[TIME_W-1:WORD_W];
                end
                REG_THI:  rdata <= WORD_W'(shadow_q);
                default:  rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/frac_time_ctr.sv
// frac_time_ctr: top of the fractional time counter. It connects the
// register port, the tick divider and the time accumulator.
// Assumes PER_W + INC_W == WORD_W, with the period in the top bits.
module frac_time_ctr
    import ftc_pkg::*;
#(
    parameter int TIME_W = 64,
    parameter int WORD_W = 32,
    parameter int PER_W  = 8,
    parameter int INC_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [1:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic [TIME_W-1:0] time_now,
    output logic              wrap_pulse
);
    logic [WORD_W-1:0] ctrl_q;
    logic [WORD_W-1:0] lo_stage;
    logic              ctrl_wr;
    logic              load;
    logic [TIME_W-1:0] load_val;
    logic              tick;
    logic [PER_W-1:0]  div_cnt;
    logic [PER_W-1:0]  period;
    logic [INC_W-1:0]  incr;

    // Split the control word into its two fields.
    always_comb begin
        period = ctrl_q[WORD_W-1 -: PER_W];
        incr   = ctrl_q[INC_W-1:0];
    end

    ftc_reg_port #(.WORD_W(WORD_W), .TIME_W(TIME_W)) port_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .rd_en    (reg_rd_en),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .time_q   (time_now),
        .ctrl_q   (ctrl_q),
        .ctrl_wr  (ctrl_wr),
        .load     (load),
        .load_val (load_val),
        .lo_stage (lo_stage),
        .rdata    (reg_rdata)
    );

    ftc_tick_div #(.PER_W(PER_W)) div_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .period  (period),
        .restart (ctrl_wr),
        .tick    (tick),
        .cnt_o   (div_cnt)
    );

    ftc_time_acc #(.TIME_W(TIME_W), .INC_W(INC_W)) acc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .incr     (incr),
        .load     (load),
        .load_val (load_val),
        .time_q   (time_now),
        .wrap     (wrap_pulse)
    );
endmodule

// File: rtl/frac_time_ctr_chk.sv
// frac_time_ctr_chk: timing properties of the fractional time counter,
// bound to every instance of frac_time_ctr.
// Assumes register address 0 is the control word and address 2 the high word.
module frac_time_ctr_chk #(
    parameter int TIME_W = 64,
    parameter int WORD_W = 32,
    parameter int PER_W  = 8,
    parameter int INC_W  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic [1:0]        reg_addr,
    input logic [WORD_W-1:0] reg_wdata,
    input logic [TIME_W-1:0] time_now,
    input logic              wrap_pulse,
    input logic [WORD_W-1:0] ctrl_q,
    input logic [WORD_W-1:0] lo_stage,
    input logic              tick,
    input logic [PER_W-1:0]  div_cnt
);
    logic hi_wr;
    assign hi_wr = reg_wr_en && (reg_addr == 2'd2);

    // R2
    stop_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[WORD_W-1 -: PER_W] == '0) |-> !tick);

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !hi_wr) |=> $stable(time_now));

    // R3
    step_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !hi_wr) |=>
        time_now == $past(time_now) + TIME_W'($past(ctrl_q[INC_W-1:0])));

    // R4
    restart_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == 2'd0) |=> (div_cnt == '0));

    // R7
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_wr |=> time_now == TIME_W'({$past(reg_wdata), $past(lo_stage)}));

    // R8
    wrap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_pulse |=> !wrap_pulse);

    // R8
    wrap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_pulse |-> (time_now < $past(time_now)));
endmodule

bind frac_time_ctr frac_time_ctr_chk #(
    .TIME_W(TIME_W), .WORD_W(WORD_W), .PER_W(PER_W), .INC_W(INC_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr_en  (reg_wr_en),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .time_now   (time_now),
    .wrap_pulse (wrap_pulse),
    .ctrl_q     (ctrl_q),
    .lo_stage   (lo_stage),
    .tick       (tick),
    .div_cnt    (div_cnt)
);

// File: tb/frac_time_ctr_tb.sv
// frac_time_ctr_tb_top: directed corner cases plus seeded random traffic,
// checked against a cycle model built from the requirements.
module frac_time_ctr_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_rd_en = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] time_now;
    logic        wrap_pulse;

    int checks = 0;
    int errors = 0;

    frac_time_ctr dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .time_now(time_now), .wrap_pulse(wrap_pulse)
    );

    always #10 clk = ~clk;

    // Requirement model, updated at each rising edge.
    logic [63:0] m_time;
    logic [31:0] m_ctrl, m_lo, m_sh, m_rd;
    logic [7:0]  m_cnt;
    logic        m_wrap;
    always @(posedge clk) begin
        logic [7:0]  p;
        logic        tk;
        logic [64:0] s;
        if (!rst_n) begin
            m_time = '0; m_ctrl = '0; m_lo = '0; m_sh = '0; m_rd = '0;
            m_cnt = '0; m_wrap = 1'b0;
        end else begin
            p  = m_ctrl[31:24];
            tk = (p != 8'd0) && (m_cnt == p - 8'd1);
            if (reg_rd_en) begin
                case (reg_addr)
                    2'd0: m_rd = m_ctrl;
                    2'd1: begin m_rd = m_time[31:0]; m_sh = m_time[63:32]; end
                    2'd2: m_rd = m_sh;
                    default: m_rd = '0;
                endcase
            end
            m_wrap = 1'b0;
            if (reg_wr_en && reg_addr == 2'd2) m_time = {reg_wdata, m_lo};
            else if (tk) begin
                s = {1'b0, m_time} + {41'd0, m_ctrl[23:0]};
                m_time = s[63:0];
                m_wrap = s[64];
            end
            if (reg_wr_en && reg_addr == 2'd1) m_lo = reg_wdata;
            if (reg_wr_en && reg_addr == 2'd0) begin m_ctrl = reg_wdata; m_cnt = '0; end
            else if (p == 8'd0 || tk) m_cnt = '0;
            else m_cnt = m_cnt + 8'd1;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a);
        reg_rd_en = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    localparam logic [31:0] INC25 = 32'd40 << 18;
    localparam logic [31:0] INC96 = 32'd125 << 17;

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] t;
        void'($urandom(32'd20240611));
        idle(3);
        // R1: values while reset is applied
        chk("R1 time", time_now, 64'd0);
        chk("R1 rdata", {32'd0, reg_rdata}, 64'd0);
        chk("R1 wrap", {63'd0, wrap_pulse}, 64'd0);
        rst_n = 1'b1;
        rd(2'd0);
        chk("R1 R5 ctrl read", {32'd0, reg_rdata}, 64'd0);
        rd(2'd2);
        chk("R1 shadow read", {32'd0, reg_rdata}, 64'd0);
        idle(20);
        chk("R2 stopped", time_now, 64'd0);

        // R3: 25 MHz setting, period 1
        wr(2'd0, {8'd1, INC25[23:0]});
        chk("R3 no step at write edge", time_now, 64'd0);
        idle(10);
        chk("R3 ten steps", time_now, 64'd10 * 64'(INC25));
        rd(2'd0);
        chk("R5 ctrl readback", {32'd0, reg_rdata}, {32'd0, 8'd1, INC25[23:0]});

        // R3, R4: 96 MHz setting, period 3, then restart
        wr(2'd0, {8'd3, INC96[23:0]});
        t = time_now;
        idle(1); chk("R3 p3 edge1", time_now, t);
        idle(1); chk("R3 p3 edge2", time_now, t);
        idle(1); chk("R3 p3 edge3", time_now, t + 64'(INC96));
        idle(1);
        wr(2'd0, {8'd3, INC96[23:0]});
        idle(1); chk("R4 no step at old phase", time_now, t + 64'(INC96));
        idle(1); chk("R4 still waiting", time_now, t + 64'(INC96));
        idle(1); chk("R4 step after restart", time_now, t + 2 * 64'(INC96));

        // R7: staged low, atomic load
        wr(2'd0, 32'd0);
        t = time_now;
        wr(2'd1, 32'h0000_1234);
        chk("R7 low write alone", time_now, t);
        wr(2'd2, 32'h0000_ABCD);
        chk("R7 loaded", time_now, 64'h0000_ABCD_0000_1234);
        wr(2'd0, {8'd1, 24'd7});
        wr(2'd1, 32'h0000_0100);
        wr(2'd2, 32'h0000_0009);
        chk("R7 load beats tick", time_now, 64'h0000_0009_0000_0100);
        idle(1);
        chk("R7 step after load", time_now, 64'h0000_0009_0000_0107);

        // R6: shadow coherency across a carry into the high word
        wr(2'd0, 32'd0);
        wr(2'd1, 32'hFFFF_FFF0);
        wr(2'd2, 32'h0000_0005);
        wr(2'd0, {8'd1, 24'd4});
        rd(2'd1);
        chk("R6 low read", {32'd0, reg_rdata}, 64'h0000_0000_FFFF_FFF0);
        idle(10);
        chk("R6 high moved on", {32'd0, time_now[63:32]}, 64'd6);
        rd(2'd2);
        chk("R6 high from shadow", {32'd0, reg_rdata}, 64'd5);
        idle(2);
        chk("R9 rdata held", {32'd0, reg_rdata}, 64'd5);

        // R8: wrap modulo 2^64 with a one-cycle pulse
        wr(2'd0, 32'd0);
        wr(2'd1, 32'hFFFF_FFF0);
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd0, {8'd1, 24'h20});
        chk("R8 before wrap", time_now, 64'hFFFF_FFFF_FFFF_FFF0);
        chk("R8 no pulse yet", {63'd0, wrap_pulse}, 64'd0);
        idle(1);
        chk("R8 wrapped value", time_now, 64'h10);
        chk("R8 pulse high", {63'd0, wrap_pulse}, 64'd1);
        idle(1);
        chk("R8 next value", time_now, 64'h30);
        chk("R8 pulse one cycle", {63'd0, wrap_pulse}, 64'd0);

        // R9: unused address
        wr(2'd0, 32'd0);
        t = time_now;
        wr(2'd3, 32'hDEAD_BEEF);
        rd(2'd3);
        chk("R9 addr3 reads zero", {32'd0, reg_rdata}, 64'd0);
        chk("R9 addr3 write no time change", time_now, t);
        rd(2'd0);
        chk("R9 addr3 write no ctrl change", {32'd0, reg_rdata}, 64'd0);

        // Random traffic against the model (R3, R6, R7, R8, R9)
        for (int i = 0; i < 400; i++) begin
            int op;
            op = int'($urandom % 8);
            case (op)
                0: wr(2'd0, {8'($urandom % 4), 24'($urandom)});
                1: wr(2'd1, (($urandom % 2) == 0) ? 32'hFFFF_FF00 : $urandom);
                2: wr(2'd2, (($urandom % 2) == 0) ? 32'hFFFF_FFFF : $urandom);
                3, 4, 5: begin
                    rd(2'($urandom % 4));
                    chk("R6 R9 random read", {32'd0, reg_rdata}, {32'd0, m_rd});
                end
                6: idle(1 + int'($urandom % 5));
                default: wr(2'd3, $urandom);
            endcase
            chk("R3 R7 random time", time_now, m_time);
            chk("R8 random wrap", {63'd0, wrap_pulse}, {63'd0, m_wrap});
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule